// File: doc/BRIEF.md
# Per-Lane PHY Error Status and SerDes Control Registers

This block is the physical-layer register slice of one port on a serial link with up to eight lanes. It holds two 32-bit registers on a plain word-access register port. Writes take effect on the clock edge and reads are combinational from the address. The configuration register carries a per-lane override that forces "receiver present" toward the link logic, and a single transmit amplitude select. The status register collects receive-side error pulses from every lane into sticky flags, which software clears by writing ones.

Capture is qualified twice. First, the link-training state code decides which error class may be recorded at all. Disparity errors count only in L0. Decode errors count in L0, Configuration, Disabled and Hot-Reset. Second, a lane-validity mask removes the upper lanes: an odd-numbered port never owns them, and an even-numbered port owns them only while it runs merged. A masked lane never records an error, reads as zero and ignores its override bit.

The link-state qualifier is built as an enumerated state decode with a `unique case`. It sorts the eight codes into three classes: both error types open (L0), decode errors only (CONFIG, DISABLED, HOT_RESET), and closed (DETECT, POLLING, RECOVERY, LOOPBACK). Each error type keeps its flags in its own sticky store. A flag takes one of two transitions each cycle. It goes clear to set on a qualified event. It goes set to clear on a one written to it, unless a qualified event arrives in the same cycle.

Top module: `phy_lane_csr`

## Requirements
- R1: After reset both registers read 0, `low_swing_o` is 0 and `rx_det_o` equals `rx_det_i`.
- R2: The configuration register sits at byte address 0x510. Bits 7:0 hold the per-lane receiver override and bit 16 the amplitude select. All other bits read 0. `low_swing_o` follows bit 16, where 0 selects full swing and 1 selects low swing.
- R3: For a valid lane with `serdes_test_i` low, `rx_det_o[i]` is `rx_det_i[i]` OR override bit i.
- R4: While `serdes_test_i` is 1, the override has no effect: `rx_det_o` equals `rx_det_i`.
- R5: The status register sits at byte address 0x51C. Bits 7:0 are disparity flags and bits 23:16 are decode flags, one per lane. Bits 15:8 and 31:24 read 0. Any other address reads 0.
- R6: A disparity flag is set by `disp_err_i[i]` only when `link_state_i` is 3 (L0).
- R7: A decode flag is set by `dec_err_i[i]` only when `link_state_i` is 2 (CONFIG), 3 (L0), 5 (DISABLED) or 6 (HOT_RESET). Codes 0, 1, 4 and 7 are ignored.
- R8: A write to 0x51C clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R9: If a clear and a qualified error hit the same flag in the same cycle, the flag is 1 afterwards.
- R10: Lanes 3:0 are always valid. Lanes 7:4 are valid only when `port_odd_i` is 0 and `merged_i` is 1. An invalid lane never sets a flag, reads 0 in both status fields and ignores its override bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_addr_i | input | 12 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| disp_err_i | input | 8 | Per-lane running-disparity error pulse |
| dec_err_i | input | 8 | Per-lane 8b/10b decode error pulse |
| link_state_i | input | 3 | Link-training state code |
| port_odd_i | input | 1 | 1 when the port number is odd |
| merged_i | input | 1 | 1 when the port runs merged over eight lanes |
| serdes_test_i | input | 1 | 1 while the port is in SerDes test mode |
| rx_det_i | input | 8 | Per-lane receiver detection result |
| rx_det_o | output | 8 | Receiver detection after override |
| low_swing_o | output | 1 | Transmit amplitude select |

## Verification
The two functions that can meet in one cycle are the software clear of a status flag and the hardware capture of a new error on the same flag. A directed case makes them collide deliberately by driving a one-hot clear on the very lane that reports an L0 disparity error. The random phase then lets clears and qualified events overlap at random. A reference model that applies the clear before the set judges every read. As a result, a flag may only drop when no qualified event was present.

// File: rtl/phy_csr_pkg.sv
package phy_csr_pkg;

    typedef enum logic [2:0] {
        LS_DETECT   = 3'd0,
        LS_POLLING  = 3'd1,
        LS_CONFIG   = 3'd2,
        LS_L0       = 3'd3,
        LS_RECOVERY = 3'd4,
        LS_DISABLED = 3'd5,
        LS_HOTRST   = 3'd6,
        LS_LOOPBACK = 3'd7
    } link_state_e;

    localparam int unsigned LINK_STATE_W = 3;

endpackage

// File: rtl/lane_valid_mask.sv
module lane_valid_mask #(
    parameter int unsigned LANES      = 8,
    parameter int unsigned BASE_LANES = 4
) (
    input  logic             port_odd_i,
    input  logic             merged_i,
    output logic [LANES-1:0] valid_o
);

    logic upper_owned;
    assign upper_owned = ~port_odd_i & merged_i;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < BASE_LANES) begin : g_base
            assign valid_o[i] = 1'b1;
        end else begin : g_upper
            assign valid_o[i] = upper_owned;
        end
    end

endmodule

// File: rtl/link_state_gate.sv
module link_state_gate
    import phy_csr_pkg::*;
(
    input  logic [LINK_STATE_W-1:0] code_i,
    output logic                    disp_ok_o,
    output logic                    dec_ok_o
);

    link_state_e st;
    assign st = link_state_e'(code_i);

    always_comb begin
        disp_ok_o = 1'b0;
        dec_ok_o  = 1'b0;
        unique case (st)
            LS_L0: begin
                disp_ok_o = 1'b1;
                dec_ok_o  = 1'b1;
            end
            LS_CONFIG, LS_DISABLED, LS_HOTRST: begin
                dec_ok_o  = 1'b1;
            end
            LS_DETECT, LS_POLLING, LS_RECOVERY, LS_LOOPBACK: begin
                disp_ok_o = 1'b0;
                dec_ok_o  = 1'b0;
            end
            default: begin
                disp_ok_o = 1'b0;
                dec_ok_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lane_err_sticky.sv
module lane_err_sticky #(
    parameter int unsigned LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] set_i,
    input  logic [LANES-1:0] clr_i,
    output logic [LANES-1:0] flags_o
);

    logic [LANES-1:0] flags_q;
    logic [LANES-1:0] flags_d;

    for (genvar i = 0; i < LANES; i++) begin : g_bit
        always_comb begin
            if (set_i[i]) begin
                flags_d[i] = 1'b1;
            end else if (clr_i[i]) begin
                flags_d[i] = 1'b0;
            end else begin
                flags_d[i] = flags_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

    AST_FLAG_DROPS_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags_q) & ~flags_q & ~$past(clr_i)) == '0)); // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_i) & ~flags_q) == '0)); // R9

endmodule

// File: rtl/phy_lane_csr.sv
module phy_lane_csr
    import phy_csr_pkg::*;
#(
    parameter int unsigned      LANES      = 8,
    parameter int unsigned      BASE_LANES = 4,
    parameter int unsigned      ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 12'h510,
    parameter logic [ADDR_W-1:0] STS_ADDR  = 12'h51C
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr_i,
    input  logic [ADDR_W-1:0]       reg_addr_i,
    input  logic [31:0]             reg_wdata_i,
    output logic [31:0]             reg_rdata_o,
    input  logic [LANES-1:0]        disp_err_i,
    input  logic [LANES-1:0]        dec_err_i,
    input  logic [LINK_STATE_W-1:0] link_state_i,
    input  logic                    port_odd_i,
    input  logic                    merged_i,
    input  logic                    serdes_test_i,
    input  logic [LANES-1:0]        rx_det_i,
    output logic [LANES-1:0]        rx_det_o,
    output logic                    low_swing_o
);

    localparam int unsigned OVR_LSB   = 0;
    localparam int unsigned SWING_BIT = 16;
    localparam int unsigned DISP_LSB  = 0;
    localparam int unsigned DEC_LSB   = 16;

    logic             cfg_wr;
    logic             sts_wr;
    logic [LANES-1:0] ovr_q;
    logic             swing_q;
    logic [LANES-1:0] lane_ok;
    logic             disp_ok;
    logic             dec_ok;
    logic [LANES-1:0] disp_set;
    logic [LANES-1:0] dec_set;
    logic [LANES-1:0] disp_clr;
    logic [LANES-1:0] dec_clr;
    logic [LANES-1:0] disp_q;
    logic [LANES-1:0] dec_q;
    logic             unused_wdata;

    assign unused_wdata = ^{reg_wdata_i[31:24], reg_wdata_i[15:8]};

    assign cfg_wr = reg_wr_i && (reg_addr_i == CFG_ADDR);
    assign sts_wr = reg_wr_i && (reg_addr_i == STS_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q   <= '0;
            swing_q <= 1'b0;
        end else if (cfg_wr) begin
            ovr_q   <= reg_wdata_i[OVR_LSB +: LANES];
            swing_q <= reg_wdata_i[SWING_BIT];
        end
    end

    lane_valid_mask #(
        .LANES      (LANES),
        .BASE_LANES (BASE_LANES)
    ) u_mask (
        .port_odd_i (port_odd_i),
        .merged_i   (merged_i),
        .valid_o    (lane_ok)
    );

    link_state_gate u_gate (
        .code_i    (link_state_i),
        .disp_ok_o (disp_ok),
        .dec_ok_o  (dec_ok)
    );

    assign disp_set = disp_err_i & lane_ok & {LANES{disp_ok}};
    assign dec_set  = dec_err_i  & lane_ok & {LANES{dec_ok}};
    assign disp_clr = {LANES{sts_wr}} & reg_wdata_i[DISP_LSB +: LANES];
    assign dec_clr  = {LANES{sts_wr}} & reg_wdata_i[DEC_LSB +: LANES];

    lane_err_sticky #(.LANES(LANES)) u_disp (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (disp_set),
        .clr_i   (disp_clr),
        .flags_o (disp_q)
    );

    lane_err_sticky #(.LANES(LANES)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (dec_set),
        .clr_i   (dec_clr),
        .flags_o (dec_q)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == CFG_ADDR) begin
            reg_rdata_o[OVR_LSB +: LANES] = ovr_q;
            reg_rdata_o[SWING_BIT]        = swing_q;
        end else if (reg_addr_i == STS_ADDR) begin
            reg_rdata_o[DISP_LSB +: LANES] = disp_q & lane_ok;
            reg_rdata_o[DEC_LSB +: LANES]  = dec_q & lane_ok;
        end
    end

    assign rx_det_o    = rx_det_i | (ovr_q & lane_ok & {LANES{~serdes_test_i}});
    assign low_swing_o = swing_q;

    AST_DISP_ONLY_IN_L0: assert property (@(posedge clk) disable iff (!rst_n)
        ((disp_q & ~$past(disp_q)) != '0) |-> ($past(link_state_i) == LS_L0)); // R6

    AST_DEC_STATE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_q & ~$past(dec_q)) != '0) |->
            ($past(link_state_i) == LS_L0 || $past(link_state_i) == LS_CONFIG ||
             $past(link_state_i) == LS_DISABLED || $past(link_state_i) == LS_HOTRST)); // R7

    AST_TEST_MODE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        serdes_test_i |-> (rx_det_o == rx_det_i)); // R4

    AST_ODD_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        port_odd_i |-> (rx_det_o[LANES-1:BASE_LANES] == rx_det_i[LANES-1:BASE_LANES])); // R10

    AST_SWING_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr) |-> (low_swing_o == $past(reg_wdata_i[SWING_BIT]))); // R2

endmodule

// File: tb/sim_phy_lane_csr.sv
`timescale 1ns/1ps
module sim_phy_lane_csr;

    localparam logic [11:0] A_CFG = 12'h510;
    localparam logic [11:0] A_STS = 12'h51C;
    localparam logic [11:0] A_BAD = 12'h520;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [11:0] reg_addr_i = A_CFG;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [7:0]  disp_err_i = '0;
    logic [7:0]  dec_err_i = '0;
    logic [2:0]  link_state_i = 3'd0;
    logic        port_odd_i = 1'b0;
    logic        merged_i = 1'b1;
    logic        serdes_test_i = 1'b0;
    logic [7:0]  rx_det_i = '0;
    logic [7:0]  rx_det_o;
    logic        low_swing_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [7:0] m_ovr = '0;
    logic       m_ls = 1'b0;
    logic [7:0] m_disp = '0;
    logic [7:0] m_dec = '0;

    always #5 clk = ~clk;

    phy_lane_csr u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_i      (reg_wr_i),
        .reg_addr_i    (reg_addr_i),
        .reg_wdata_i   (reg_wdata_i),
        .reg_rdata_o   (reg_rdata_o),
        .disp_err_i    (disp_err_i),
        .dec_err_i     (dec_err_i),
        .link_state_i  (link_state_i),
        .port_odd_i    (port_odd_i),
        .merged_i      (merged_i),
        .serdes_test_i (serdes_test_i),
        .rx_det_i      (rx_det_i),
        .rx_det_o      (rx_det_o),
        .low_swing_o   (low_swing_o)
    );

    function automatic logic [7:0] f_valid(logic odd, logic mrg);
        return (!odd && mrg) ? 8'hFF : 8'h0F;
    endfunction

    function automatic logic f_dec_open(logic [2:0] s);
        return (s == 3'd2) || (s == 3'd3) || (s == 3'd5) || (s == 3'd6);
    endfunction

    function automatic logic [31:0] f_read(logic [11:0] a);
        logic [7:0] v;
        v = f_valid(port_odd_i, merged_i);
        if (a == A_CFG) return {15'd0, m_ls, 8'd0, m_ovr};
        if (a == A_STS) return {8'd0, m_dec & v, 8'd0, m_disp & v};
        return 32'd0;
    endfunction

    function automatic logic [7:0] f_rxdet();
        return rx_det_i | (m_ovr & f_valid(port_odd_i, merged_i) & {8{~serdes_test_i}});
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock edge; reference model applies the clear first, then the set
    task automatic tick();
        logic [7:0] v;
        @(posedge clk);
        v = f_valid(port_odd_i, merged_i);
        if (reg_wr_i && reg_addr_i == A_CFG) begin
            m_ovr = reg_wdata_i[7:0];
            m_ls  = reg_wdata_i[16];
        end
        if (reg_wr_i && reg_addr_i == A_STS) begin
            m_disp = m_disp & ~reg_wdata_i[7:0];
            m_dec  = m_dec & ~reg_wdata_i[23:16];
        end
        if (link_state_i == 3'd3) m_disp = m_disp | (disp_err_i & v);
        if (f_dec_open(link_state_i)) m_dec = m_dec | (dec_err_i & v);
        #1;
        reg_wr_i   = 1'b0;
        disp_err_i = '0;
        dec_err_i  = '0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_addr_i  = a;
        reg_wdata_i = d;
        reg_wr_i    = 1'b1;
        tick();
    endtask

    task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
        reg_addr_i = a;
        #1;
        chk(req, reg_rdata_o, exp);
    endtask

    task automatic pulse(logic [2:0] s, logic [7:0] dsp, logic [7:0] dcd);
        link_state_i = s;
        disp_err_i   = dsp;
        dec_err_i    = dcd;
        tick();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rx_det_i = 8'h21;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;

        // R1 reset state
        rd("R1 cfg", A_CFG, 32'h0);
        rd("R1 sts", A_STS, 32'h0);
        chk("R1 low_swing", {31'd0, low_swing_o}, 32'd0);
        chk("R1 rx_det", {24'd0, rx_det_o}, {24'd0, rx_det_i});

        // R2 field layout and amplitude select
        wr(A_CFG, 32'hFFFF_FFFF);
        rd("R2 cfg readback", A_CFG, 32'h0001_00FF);
        chk("R2 low_swing", {31'd0, low_swing_o}, 32'd1);
        // R3 override on valid lanes
        rx_det_i = 8'h00; #1;
        chk("R3 override", {24'd0, rx_det_o}, 32'hFF);
        // R4 test mode bypass
        serdes_test_i = 1'b1; #1;
        chk("R4 test mode", {24'd0, rx_det_o}, 32'h00);
        serdes_test_i = 1'b0;
        // R10 upper lanes ignored on an odd port
        port_odd_i = 1'b1; #1;
        chk("R10 odd override", {24'd0, rx_det_o}, 32'h0F);
        port_odd_i = 1'b0; merged_i = 1'b0; #1;
        chk("R10 unmerged override", {24'd0, rx_det_o}, 32'h0F);
        merged_i = 1'b1;
        wr(A_CFG, 32'h0000_0000);
        chk("R2 full swing", {31'd0, low_swing_o}, 32'd0);

        // R5 R6 R7 capture in L0
        pulse(3'd3, 8'hFF, 8'hFF);
        rd("R5 R6 R7 L0 capture", A_STS, 32'h00FF_00FF);
        rd("R5 unmapped", A_BAD, 32'h0);

        // R8 write-one-to-clear
        wr(A_STS, 32'hFF0F_FF0F);
        rd("R8 clear ones", A_STS, 32'h00F0_00F0);
        wr(A_STS, 32'h0000_0000);
        rd("R8 zero keeps", A_STS, 32'h00F0_00F0);

        // R9 same-cycle collision on lane 4
        link_state_i = 3'd3;
        disp_err_i   = 8'h10;
        wr(A_STS, 32'h0000_0010);
        rd("R9 set wins", A_STS, 32'h00F0_00F0);
        wr(A_STS, 32'h00FF_00FF);
        rd("R8 all clear", A_STS, 32'h0);

        // R6 R7 non-L0 states
        pulse(3'd2, 8'hFF, 8'h0F);
        rd("R6 R7 config", A_STS, 32'h000F_0000);
        pulse(3'd1, 8'hFF, 8'hF0);
        pulse(3'd4, 8'hFF, 8'hF0);
        pulse(3'd7, 8'hFF, 8'hF0);
        pulse(3'd0, 8'hFF, 8'hF0);
        rd("R7 closed states ignored", A_STS, 32'h000F_0000);
        pulse(3'd5, 8'h00, 8'h30);
        pulse(3'd6, 8'h00, 8'hC0);
        rd("R7 disabled hot reset", A_STS, 32'h00FF_0000);
        wr(A_STS, 32'hFFFF_FFFF);

        // R10 capture masking
        port_odd_i = 1'b1;
        pulse(3'd3, 8'hFF, 8'hFF);
        rd("R10 odd capture", A_STS, 32'h000F_000F);
        port_odd_i = 1'b0; #1;
        rd("R10 upper never set", A_STS, 32'h000F_000F);
        merged_i = 1'b0;
        pulse(3'd3, 8'hF0, 8'hF0);
        merged_i = 1'b1; #1;
        rd("R10 unmerged capture", A_STS, 32'h000F_000F);

        // random phase against the reference model
        for (int it = 0; it < 600; it++) begin
            int pick;
            link_state_i  = 3'($urandom_range(0, 7));
            disp_err_i    = 8'($urandom);
            dec_err_i     = 8'($urandom) & 8'($urandom);
            port_odd_i    = ($urandom_range(0, 3) == 0);
            merged_i      = ($urandom_range(0, 3) != 0);
            serdes_test_i = ($urandom_range(0, 5) == 0);
            rx_det_i      = 8'($urandom);
            pick = $urandom_range(0, 9);
            reg_wr_i    = (pick < 4);
            reg_addr_i  = (pick < 1) ? A_CFG : (pick < 4) ? A_STS : A_BAD;
            reg_wdata_i = $urandom;
            tick();
            pick = $urandom_range(0, 4);
            reg_addr_i = (pick == 0) ? A_CFG : (pick == 4) ? A_BAD : A_STS;
            #1;
            chk("R5 R6 R7 R8 R9 R10 random read", reg_rdata_o, f_read(reg_addr_i));
            chk("R3 R4 random rx_det", {24'd0, rx_det_o}, {24'd0, f_rxdet()});
            chk("R2 random swing", {31'd0, low_swing_o}, {31'd0, m_ls});
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule